// File: doc/BRIEF.md
# Coprocessor Handshake and Transfer Controller

This block is the core-side sequencer for instructions handed to an attached coprocessor. When an instruction is issued, it drops an active-low coprocessor strobe and samples two response lines from the coprocessor: an "absent" line and a "busy" line. The two lines give three meanings during the handshake. Both high means no coprocessor can do the work, so the controller raises an undefined-instruction trap request. Absent low with busy high means the coprocessor has accepted the work but cannot commit yet, so the controller busy-waits with the address held at the instruction's fetch address. Both low means the coprocessor has committed.

Once a plain data operation is committed, the controller resumes instruction fetch one word past the fetch address. For a memory-to-coprocessor transfer, it first emits the computed base address. It then steps through word addresses at sequential rate and writes the advancing base back each cycle. The coprocessor, not the core, decides the burst length: it marks the final word by driving both lines high. An interrupt-abandon input can end a busy-wait early, and the controller then reports that the instruction was not executed.

Top module: `cpx_xfer_ctrl`

## Requirements
- R1: After reset the controller is idle: `cop_strobe_n` is 1, and `mem_req`, `undef_trap`, `abandoned`, `base_we` and `done` are 0.
- R2: In a handshake cycle with `cp_absent`=1 and `cp_busy`=1, `undef_trap` is 1 and `mem_req` is 0 in that cycle. The next cycle is idle, with `cop_strobe_n`=1.
- R3: In a handshake cycle with `cp_absent`=0 and `cp_busy`=1, `cop_strobe_n` is 0, `mem_req` is 0 and `addr` equals the captured `fetch_pc`. `opc_fetch` is 1 only in the first handshake cycle.
- R4: In a handshake cycle with both lines at 0, `mem_req` is 1. If `op_xfer`=0 (data operation), the next cycle shows `done`=1, `opc_fetch`=1 and `addr` = `fetch_pc`+4.
- R5: If `op_xfer`=1 (transfer), after commit the first transfer cycle drives `addr` = `base_addr`, and each later transfer cycle adds 4. Every transfer cycle has `cop_strobe_n`=1 and `mem_req`=1.
- R6: `seq` is 1 on every transfer cycle except the last one, where it is 0.
- R7: A transfer cycle with both lines at 1 is the last word. The next cycle shows `done`=1 and `addr` = `fetch_pc`+4.
- R8: In every transfer cycle `base_we` is 1 and `base_wb` equals that cycle's `addr`+4.
- R9: `irq_abandon`=1 in a busy handshake cycle gives `abandoned`=1 in that cycle, and the next cycle is idle (`cop_strobe_n`=1, `mem_req`=0). In a commit cycle, `irq_abandon` has no effect.
- R10: `start`, `op_xfer`, `fetch_pc` and `base_addr` are sampled only when idle. A `start` pulse during a busy-wait does not change `addr` or the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue a coprocessor instruction (taken when idle) |
| op_xfer | input | 1 | 1 = memory-to-coprocessor transfer, 0 = data operation |
| fetch_pc | input | ADDR_W | Fetch address of the instruction stream during the handshake |
| base_addr | input | ADDR_W | Computed base address for a transfer |
| cp_absent | input | 1 | Coprocessor response line: absent |
| cp_busy | input | 1 | Coprocessor response line: busy |
| irq_abandon | input | 1 | Abandon the busy-wait for an interrupt |
| addr | output | ADDR_W | Memory address |
| mem_req | output | 1 | Memory request, active high |
| seq | output | 1 | Next access is sequential |
| opc_fetch | output | 1 | Current access is an opcode fetch |
| cop_strobe_n | output | 1 | Coprocessor instruction strobe, active low |
| undef_trap | output | 1 | Undefined-instruction trap request |
| abandoned | output | 1 | Instruction abandoned, not executed |
| base_we | output | 1 | Base write-back enable |
| base_wb | output | ADDR_W | Updated base value |
| done | output | 1 | Instruction completed, fetch resumes |

## Verification
Each issued instruction is driven through a response pattern: an immediate trap, an immediate commit, or a commit after zero to three busy cycles, optionally ended by an abandon. Zero busy cycles and several busy cycles exercise the first-cycle opcode flag and the held address. Trap and abandon show the two early exits apart from normal completion. Transfers of one word and of several words distinguish a burst that ends in its first transfer cycle from a longer one, using the sequential flag, the address step and the written-back base. Junk on `start` and the issue fields during busy-waits, and an abandon driven during commit cycles, show that these inputs are ignored.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HAND   = 2'd1,
    ST_XFER   = 2'd2,
    ST_RESUME = 2'd3
  } cpx_state_e;

  // Meaning of the two coprocessor lines
  typedef enum logic [1:0] {
    RSP_COMMIT = 2'd0,  // absent=0 busy=0
    RSP_BUSY   = 2'd1,  // absent=0 busy=1
    RSP_NONE   = 2'd2,  // absent=1 busy=1 (no taker / last word)
    RSP_ODD    = 2'd3   // absent=1 busy=0
  } cpx_rsp_e;
endpackage

// File: rtl/cpx_rst_sync.sv
module cpx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cpx_rsp_decode.sv
module cpx_rsp_decode
  import cpx_pkg::*;
(
  input  logic     cp_absent,
  input  logic     cp_busy,
  output cpx_rsp_e rsp
);
  always_comb begin
    unique case ({cp_absent, cp_busy})
      2'b00:   rsp = RSP_COMMIT;
      2'b01:   rsp = RSP_BUSY;
      2'b11:   rsp = RSP_NONE;
      default: rsp = RSP_ODD;
    endcase
  end
endmodule

// File: rtl/cpx_seq_fsm.sv
module cpx_seq_fsm
  import cpx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       op_xfer,
  input  cpx_rsp_e   rsp,
  input  logic       irq_abandon,
  output cpx_state_e state,
  output logic       first
);
  cpx_state_e state_q, state_d;
  logic       first_q, first_d;
  logic       op_q, op_d;

  always_comb begin
    state_d = state_q;
    first_d = 1'b0;
    op_d    = op_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HAND;
          first_d = 1'b1;
          op_d    = op_xfer;
        end
      end
      ST_HAND: begin
        unique case (rsp)
          RSP_COMMIT: state_d = op_q ? ST_XFER : ST_RESUME;
          RSP_BUSY:   state_d = irq_abandon ? ST_IDLE : ST_HAND;
          default:    state_d = ST_IDLE;
        endcase
      end
      ST_XFER:   if (rsp == RSP_NONE) state_d = ST_RESUME;
      ST_RESUME: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      op_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= first_d;
      op_q    <= op_d;
    end
  end

  assign state = state_q;
  assign first = first_q;

  // R9: an abandoned busy-wait leaves the handshake at once
  p_abandon_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HAND && rsp == RSP_BUSY && irq_abandon) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/cpx_addr_gen.sv
module cpx_addr_gen
  import cpx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cpx_state_e        state,
  input  logic              capture,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base_wb
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              pc_en, ptr_en;
  logic [ADDR_W-1:0] ptr_next;

  assign ptr_next = ptr_q + STEP;
  assign pc_en    = capture;
  assign ptr_en   = capture || (state == ST_XFER);
  assign pc_d     = fetch_pc;
  assign ptr_d    = capture ? base_addr : ptr_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ptr_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (ptr_en) ptr_q <= ptr_d;
    end
  end

  always_comb begin
    unique case (state)
      ST_XFER:   addr = ptr_q;
      ST_RESUME: addr = pc_q + STEP;
      default:   addr = pc_q;
    endcase
  end

  assign base_wb = ptr_next;

  // R5: consecutive transfer cycles step by one word
  p_xfer_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_XFER && $past(state) == ST_XFER) |-> (addr == $past(addr) + STEP));
endmodule

// File: rtl/cpx_xfer_ctrl.sv
module cpx_xfer_ctrl
  import cpx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_xfer,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              cp_absent,
  input  logic              cp_busy,
  input  logic              irq_abandon,
  output logic [ADDR_W-1:0] addr,
  output logic              mem_req,
  output logic              seq,
  output logic              opc_fetch,
  output logic              cop_strobe_n,
  output logic              undef_trap,
  output logic              abandoned,
  output logic              base_we,
  output logic [ADDR_W-1:0] base_wb,
  output logic              done
);
  logic       rst_i_n;
  cpx_rsp_e   rsp;
  cpx_state_e state;
  logic       first;
  logic       in_idle, in_hand, in_xfer, in_resume;

  cpx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  cpx_rsp_decode u_dec (
    .cp_absent(cp_absent), .cp_busy(cp_busy), .rsp(rsp)
  );

  cpx_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .start(start), .op_xfer(op_xfer),
    .rsp(rsp), .irq_abandon(irq_abandon), .state(state), .first(first)
  );

  assign in_idle   = (state == ST_IDLE);
  assign in_hand   = (state == ST_HAND);
  assign in_xfer   = (state == ST_XFER);
  assign in_resume = (state == ST_RESUME);

  cpx_addr_gen #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_agen (
    .clk(clk), .rst_n(rst_i_n), .state(state), .capture(in_idle && start),
    .fetch_pc(fetch_pc), .base_addr(base_addr), .addr(addr), .base_wb(base_wb)
  );

  assign cop_strobe_n = !in_hand;
  assign mem_req      = (in_hand && rsp == RSP_COMMIT) || in_xfer || in_resume;
  assign seq          = in_xfer && (rsp != RSP_NONE);
  assign opc_fetch    = (in_hand && first) || in_resume;
  assign undef_trap   = in_hand && (rsp == RSP_NONE || rsp == RSP_ODD);
  assign abandoned    = in_hand && (rsp == RSP_BUSY) && irq_abandon;
  assign base_we      = in_xfer;
  assign done         = in_resume;

  // R2: a trap request is followed by an idle cycle
  p_undef_exit_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    undef_trap |=> (cop_strobe_n && !mem_req));

  // R3: busy-wait keeps the strobe low and the address still
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cop_strobe_n && !cp_absent && cp_busy && !irq_abandon)
      |=> (!cop_strobe_n && addr == $past(addr)));

  // R7: the last transfer word is followed by completion
  p_last_done_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    (base_we && cp_absent && cp_busy) |=> done);

  // R9: after an abandon the strobe is released
  p_abandon_idle_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    abandoned |=> (cop_strobe_n && !mem_req));
endmodule

// File: tb/cpx_xfer_ctrl_tb.sv
module cpx_xfer_ctrl_tb;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, op_xfer, cp_absent, cp_busy, irq_abandon;
  logic [AW-1:0] fetch_pc, base_addr;
  logic [AW-1:0] addr, base_wb;
  logic          mem_req, seq, opc_fetch, cop_strobe_n;
  logic          undef_trap, abandoned, base_we, done;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;  // 50 MHz

  cpx_xfer_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_xfer(op_xfer),
    .fetch_pc(fetch_pc), .base_addr(base_addr), .cp_absent(cp_absent),
    .cp_busy(cp_busy), .irq_abandon(irq_abandon), .addr(addr),
    .mem_req(mem_req), .seq(seq), .opc_fetch(opc_fetch),
    .cop_strobe_n(cop_strobe_n), .undef_trap(undef_trap),
    .abandoned(abandoned), .base_we(base_we), .base_wb(base_wb), .done(done)
  );

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] word_addr(logic [AW-1:0] b, int k);
    return b + AW'(4 * k);
  endfunction

  task automatic chk_idle(string tag);
    chk({tag, " strobe_n"}, AW'(cop_strobe_n), 1);
    chk({tag, " mem_req"},  AW'(mem_req), 0);
    chk({tag, " done"},     AW'(done), 0);
  endtask

  // mode: 0 normal, 1 no coprocessor, 2 abandon in last busy cycle
  task automatic run_instr(bit op, logic [AW-1:0] pc, logic [AW-1:0] base,
                           int nbusy, int nwords, int mode);
    @(negedge clk);
    start = 1'b1; op_xfer = op; fetch_pc = pc; base_addr = base;
    cp_absent = 1'b0; cp_busy = 1'b0; irq_abandon = 1'b0;
    #5 chk_idle("R1 idle before issue");
    @(negedge clk);
    start = 1'b0; fetch_pc = $urandom; base_addr = $urandom; op_xfer = $urandom;
    if (mode == 1) begin
      cp_absent = 1'b1; cp_busy = 1'b1;
      #5;
      chk("R2 undef_trap", AW'(undef_trap), 1);
      chk("R2 mem_req",    AW'(mem_req), 0);
      chk("R3 addr held",  addr, pc);
      @(negedge clk);
      cp_absent = 1'b0; cp_busy = 1'b0;
      #5 chk_idle("R2 after trap");
      return;
    end
    for (int i = 0; i < nbusy; i++) begin
      cp_absent = 1'b0; cp_busy = 1'b1;
      irq_abandon = (mode == 2 && i == nbusy - 1);
      start = $urandom_range(0, 1);  // R10 junk issue
      op_xfer = $urandom; fetch_pc = $urandom; base_addr = $urandom;
      #5;
      chk("R3 strobe low",  AW'(cop_strobe_n), 0);
      chk("R3 mem_req low", AW'(mem_req), 0);
      chk("R3 R10 addr held", addr, pc);
      chk("R3 opc_fetch",   AW'(opc_fetch), AW'(i == 0));
      if (irq_abandon) begin
        chk("R9 abandoned", AW'(abandoned), 1);
        @(negedge clk);
        start = 1'b0; irq_abandon = 1'b0; cp_busy = 1'b0;
        #5 chk_idle("R9 after abandon");
        return;
      end
      @(negedge clk);
    end
    start = 1'b0;
    cp_absent = 1'b0; cp_busy = 1'b0;
    irq_abandon = $urandom_range(0, 1);  // R9: ignored on commit
    #5;
    chk("R4 commit mem_req", AW'(mem_req), 1);
    chk("R4 commit addr",    addr, pc);
    chk("R3 opc_fetch commit", AW'(opc_fetch), AW'(nbusy == 0));
    chk("R9 no abandon on commit", AW'(abandoned), 0);
    @(negedge clk);
    irq_abandon = 1'b0;
    if (op) begin
      for (int w = 0; w < nwords; w++) begin
        bit last = (w == nwords - 1);
        cp_absent = last; cp_busy = last;
        #5;
        chk("R5 xfer addr",     addr, word_addr(base, w));
        chk("R5 strobe high",   AW'(cop_strobe_n), 1);
        chk("R5 mem_req",       AW'(mem_req), 1);
        chk("R6 seq",           AW'(seq), AW'(!last));
        chk("R8 base_we",       AW'(base_we), 1);
        chk("R8 base_wb",       base_wb, word_addr(base, w + 1));
        @(negedge clk);
      end
    end
    cp_absent = 1'b0; cp_busy = 1'b0;
    #5;
    chk("R4 R7 done",       AW'(done), 1);
    chk("R4 R7 resume addr", addr, pc + 4);
    chk("R4 resume opc",    AW'(opc_fetch), 1);
    @(negedge clk);
    #5 chk_idle("R1 idle after done");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; op_xfer = 1'b0; fetch_pc = '0; base_addr = '0;
    cp_absent = 1'b0; cp_busy = 1'b0; irq_abandon = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    chk("R1 reset strobe_n", AW'(cop_strobe_n), 1);
    chk("R1 reset trap",     AW'(undef_trap), 0);
    chk("R1 reset base_we",  AW'(base_we), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5 chk_idle("R1 after reset");

    // directed corners
    run_instr(1'b0, 32'h0000_1008, 32'h0, 0, 0, 0);  // data op, immediate commit
    run_instr(1'b0, 32'h0000_2008, 32'h0, 3, 0, 0);  // data op after busy-wait
    run_instr(1'b1, 32'h0000_3008, 32'h8000_0000, 0, 1, 0);  // single word
    run_instr(1'b1, 32'h0000_4008, 32'hFFFF_FFF8, 2, 4, 0);  // burst, wraps
    run_instr(1'b1, 32'h0000_5008, 32'h0, 0, 0, 1);  // no coprocessor
    run_instr(1'b1, 32'h0000_6008, 32'h100, 1, 3, 2);  // abandon at once
    run_instr(1'b0, 32'h0000_7008, 32'h0, 3, 0, 2);  // abandon after waiting

    for (int k = 0; k < 200; k++) begin
      int mode  = $urandom_range(0, 5);
      int nb    = $urandom_range(0, 3);
      int nw    = $urandom_range(1, 5);
      bit op    = $urandom_range(0, 1);
      logic [AW-1:0] pc = {$urandom, 2'b00};
      logic [AW-1:0] bs = {$urandom, 2'b00};
      if (mode > 2) mode = 0;
      if (mode == 2 && nb == 0) nb = 1;
      run_instr(op, pc, bs, nb, nw, mode);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule